// File: doc/BRIEF.md
# Sequential Matrix Multiply Engine

This block computes the product of two square N-by-N matrices of signed integers. The operands sit in two internal single-port memories, A and B, and the product goes into a third single-port memory, C. All three are stored row-major in flat address spaces. A host fills A and B through a shared load port while the engine is not running. It pulses `start` and waits for `ready`, then reads C back one word per cycle through a registered read port.

The work is spread over many clock cycles so that a single multiply-accumulate unit can serve the whole matrix. After a start, the controller first zeroes every C word, one word per cycle, because C has only one write port. It then walks the row, column and inner indices held in registers and forms one product per cycle. The running sum restarts at zero for each output cell, and one extra cycle per cell writes the finished sum. With N inner steps and one write step per cell, a run lasts N*N*(N+2) cycles in total. The dimension is a parameter. A reference dimension of 128 works with the same logic, and the default is kept small.

Top module: `seq_matmul`

## Requirements
- R1: After a start is accepted, the engine spends exactly N*N cycles writing zero to C addresses 0, 1, ..., N*N-1 in that order, one per cycle, before it forms any product.
- R2: C word i*N+j holds the sum over k of A[i*N+k]*B[k*N+j]. Operands are DW-bit signed two's complement and all matrices are row-major.
- R3: C words are 2*DW bits wide. Each stores the low 2*DW bits of the exact sum, so an out-of-range sum wraps modulo 2^(2*DW). The internal accumulator is wide enough that N products never overflow it.
- R4: The running sum restarts from zero at the first product of every output cell, so no cell depends on the previous one.
- R5: One product is accumulated per cycle and each cell takes N+1 cycles. `ready` rises exactly N*N*(N+2) rising edges after the edge that accepts `start`.
- R6: `ready` is low from the accepting edge until the last C word has been written. It then stays high until the next start is accepted.
- R7: A `start` pulse that arrives while a run is in progress is ignored.
- R8: While a run is in progress, load writes to A and B are ignored.
- R9: When idle or done, `a_we`/`b_we` write `ld_data` to `ld_addr` of A/B, and `c_rd_data` presents C[`c_rd_addr`] one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when not running) |
| ready | output | 1 | High once the product is complete |
| a_we | input | 1 | Write `ld_data` into A at `ld_addr` |
| b_we | input | 1 | Write `ld_data` into B at `ld_addr` |
| ld_addr | input | log2(N*N) | Row-major load address |
| ld_data | input | DW | Signed operand word |
| c_rd_addr | input | log2(N*N) | Row-major readback address for C |
| c_rd_data | output | 2*DW | C word, registered, one cycle after address |

## Verification
The accumulation of a cell's last product and the write of that cell's sum into C fall in the same cycle. The written value is taken from the adder's output rather than from the accumulator register. To provoke this, one pattern makes every inner term zero except k = N-1, so a missed or late final accumulate leaves a visibly wrong C word. Every C word of every pattern, including wrapped extreme-value sums, is compared against sums formed arithmetically in the bench. The bench also counts the cycles from the accepting edge to `ready`, with a stray start and a stray A write injected mid-run.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_MAC   = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } mm_state_e;
endpackage

// File: rtl/mm_ram.sv
module mm_ram #(
    parameter int W = 8,
    parameter int D = 16,
    localparam int AW = $clog2(D)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [D];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
        rdata_q <= mem_q[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
    parameter int DW   = 8,
    parameter int ACCW = 19,
    localparam int CW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          first,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [CW-1:0] res
);
    logic signed [CW-1:0]   prod;
    logic signed [ACCW-1:0] prod_ext;
    logic signed [ACCW-1:0] sum;
    logic signed [ACCW-1:0] acc_d, acc_q;

    always_comb begin
        prod     = $signed(a) * $signed(b);
        prod_ext = {{(ACCW-CW){prod[CW-1]}}, prod};
        sum      = (first ? '0 : acc_q) + prod_ext;
        acc_d    = valid ? sum : acc_q;
        res      = sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R4: first product of a cell replaces, not adds to, the old sum
    assert_cell_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && first) |=> (acc_q == $past(prod_ext)));
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int N    = 4,
    localparam int NN  = N * N,
    localparam int AW  = $clog2(NN),
    localparam int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] a_addr,
    output logic [AW-1:0] b_addr,
    output logic [AW-1:0] c_addr,
    output logic          c_we,
    output logic          c_clr,
    output logic          rd_valid,
    output logic          rd_first,
    output logic          busy,
    output logic          ready
);
    localparam logic [IW-1:0] LAST_IDX  = IW'(N - 1);
    localparam logic [AW-1:0] LAST_CELL = AW'(NN - 1);
    localparam logic [AW-1:0] NW        = AW'(N);

    typedef struct packed {
        mm_state_e     st;
        logic [IW-1:0] i;
        logic [IW-1:0] j;
        logic [IW-1:0] k;
        logic [AW-1:0] cnt;
        logic          vld;
        logic          fst;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d     = q;
        d.vld = (q.st == ST_MAC);
        d.fst = (q.k == '0);
        case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    d.st  = ST_CLEAR;
                    d.cnt = '0;
                end
            end
            ST_CLEAR: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST_CELL) begin
                    d.st = ST_MAC;
                    d.i  = '0;
                    d.j  = '0;
                    d.k  = '0;
                end
            end
            ST_MAC: begin
                if (q.k == LAST_IDX) begin
                    d.k  = '0;
                    d.st = ST_WRITE;
                end else begin
                    d.k = q.k + 1'b1;
                end
            end
            ST_WRITE: begin
                d.st = ST_MAC;
                if (q.j == LAST_IDX) begin
                    d.j = '0;
                    if (q.i == LAST_IDX) begin
                        d.i  = '0;
                        d.st = ST_DONE;
                    end else begin
                        d.i = q.i + 1'b1;
                    end
                end else begin
                    d.j = q.j + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        a_addr   = AW'(q.i) * NW + AW'(q.k);
        b_addr   = AW'(q.k) * NW + AW'(q.j);
        c_clr    = (q.st == ST_CLEAR);
        c_we     = (q.st == ST_CLEAR) || (q.st == ST_WRITE);
        c_addr   = c_clr ? q.cnt : (AW'(q.i) * NW + AW'(q.j));
        rd_valid = q.vld;
        rd_first = q.fst;
        busy     = (q.st == ST_CLEAR) || (q.st == ST_MAC) || (q.st == ST_WRITE);
        ready    = (q.st == ST_DONE);
    end

    // R1: the clearing sweep moves one address per cycle
    assert_clear_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CLEAR && $past(q.st) == ST_CLEAR) |-> (q.cnt == $past(q.cnt) + 1'b1));

    // R5: the inner index advances by one on every consecutive product cycle
    assert_inner_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MAC && $past(q.st) == ST_MAC) |-> (q.k == $past(q.k) + 1'b1));

    // R1: products start only after the last clear address
    assert_clear_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MAC && $past(q.st) == ST_CLEAR) |-> ($past(q.cnt) == LAST_CELL));
endmodule

// File: rtl/seq_matmul.sv
module seq_matmul #(
    parameter int N    = 4,
    parameter int DW   = 8,
    localparam int NN   = N * N,
    localparam int AW   = $clog2(NN),
    localparam int CW   = 2 * DW,
    localparam int ACCW = CW + $clog2(N) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          ready,
    input  logic          a_we,
    input  logic          b_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] c_rd_addr,
    output logic [CW-1:0] c_rd_data
);
    logic [AW-1:0] eng_a_addr, eng_b_addr, eng_c_addr;
    logic          eng_c_we, eng_c_clr, rd_valid, rd_first, busy;
    logic [AW-1:0] a_addr, b_addr, c_addr;
    logic [DW-1:0] a_rdata, b_rdata;
    logic [CW-1:0] c_wdata, mac_res;

    mm_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .a_addr   (eng_a_addr),
        .b_addr   (eng_b_addr),
        .c_addr   (eng_c_addr),
        .c_we     (eng_c_we),
        .c_clr    (eng_c_clr),
        .rd_valid (rd_valid),
        .rd_first (rd_first),
        .busy     (busy),
        .ready    (ready)
    );

    always_comb begin
        a_addr  = busy ? eng_a_addr : ld_addr;
        b_addr  = busy ? eng_b_addr : ld_addr;
        c_addr  = busy ? eng_c_addr : c_rd_addr;
        c_wdata = eng_c_clr ? '0 : mac_res;
    end

    mm_ram #(.W(DW), .D(NN)) u_a_mem (
        .clk(clk), .we(a_we && !busy), .addr(a_addr), .wdata(ld_data), .rdata(a_rdata)
    );

    mm_ram #(.W(DW), .D(NN)) u_b_mem (
        .clk(clk), .we(b_we && !busy), .addr(b_addr), .wdata(ld_data), .rdata(b_rdata)
    );

    mm_ram #(.W(CW), .D(NN)) u_c_mem (
        .clk(clk), .we(eng_c_we), .addr(c_addr), .wdata(c_wdata), .rdata(c_rd_data)
    );

    mm_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (rd_valid),
        .first (rd_first),
        .a     (a_rdata),
        .b     (b_rdata),
        .res   (mac_res)
    );

    // R6: completion flag follows the write of the final C word
    assert_ready_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(eng_c_we) && !$past(eng_c_clr) && $past(eng_c_addr) == AW'(NN - 1)));

    // R1: every clear-phase write stores zero
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_c_clr |-> (eng_c_we && c_wdata == '0));
endmodule

// File: tb/tb_seq_matmul.sv
module tb_seq_matmul;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int NN = N * N;
    localparam int AW = $clog2(NN);
    localparam int CW = 2 * DW;
    localparam int RUN_CYCLES = NN * (N + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready;
    logic          a_we = 1'b0, b_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [AW-1:0] c_rd_addr = '0;
    logic [CW-1:0] c_rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int ma [NN];
    int mb [NN];

    seq_matmul #(.N(N), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .a_we(a_we), .b_we(b_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .c_rd_addr(c_rd_addr), .c_rd_data(c_rd_data)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_mats();
        for (int x = 0; x < NN; x++) begin
            @(negedge clk);
            a_we = 1'b1; b_we = 1'b0; ld_addr = AW'(x); ld_data = DW'(ma[x]);
            @(negedge clk);
            a_we = 1'b0; b_we = 1'b1; ld_data = DW'(mb[x]);
        end
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    // disturb: inject a stray start and a stray A write mid-run (R7, R8)
    task automatic run_mult(input bit disturb);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R6 ready low after start", int'(ready), 0);
        cyc = 0;
        while (!ready && cyc < 10 * RUN_CYCLES) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (disturb && cyc == 20) begin
                start = 1'b1; a_we = 1'b1; ld_addr = '0; ld_data = 8'd99;
            end else begin
                start = 1'b0; a_we = 1'b0;
            end
        end
        start = 1'b0; a_we = 1'b0;
        check("R5 R1 R7 start-to-ready cycles", cyc, RUN_CYCLES);
        repeat (5) @(negedge clk);
        check("R6 ready held until next start", int'(ready), 1);
    endtask

    function automatic int exp_c(input int x);
        int i, j, s;
        i = x / N;
        j = x % N;
        s = 0;
        for (int k = 0; k < N; k++) s += ma[i*N+k] * mb[k*N+j];
        return s & 32'hFFFF;
    endfunction

    task automatic check_c(input string tag);
        for (int x = 0; x < NN; x++) begin
            @(negedge clk);
            c_rd_addr = AW'(x);
            @(negedge clk);
            check(tag, int'(c_rd_data), exp_c(x));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset ready low", int'(ready), 0);

        // identity times B gives B (R2, R9)
        for (int x = 0; x < NN; x++) begin
            ma[x] = ((x / N) == (x % N)) ? 1 : 0;
            ma[x] = ma[x];
            mb[x] = x - 8;
        end
        load_mats();
        run_mult(1'b0);
        check_c("R2 R9 identity product");

        // mixed-sign pattern, with stray start and A write mid-run (R4, R7, R8)
        for (int x = 0; x < NN; x++) begin
            ma[x] = ((x * 7) % 23) - 11;
            mb[x] = ((x * 5) % 19) - 9;
        end
        load_mats();
        run_mult(1'b1);
        check_c("R2 R4 R8 mixed-sign product");

        // rerun without reload: A must still hold original data (R8)
        run_mult(1'b0);
        check_c("R8 rerun after ignored load");

        // extremes: -128*-128*4 = 65536 wraps to 0 (R3)
        for (int x = 0; x < NN; x++) begin
            ma[x] = -128;
            mb[x] = -128;
        end
        load_mats();
        run_mult(1'b0);
        check_c("R3 wrap of most-positive sum");

        // extremes: 127*-128*4 = -65024 stores as 512 (R3)
        for (int x = 0; x < NN; x++) begin
            ma[x] = 127;
            mb[x] = -128;
        end
        load_mats();
        run_mult(1'b0);
        check_c("R3 wrap of negative sum");

        // only the last inner term is nonzero: final accumulate meets write (R2, R5)
        for (int x = 0; x < NN; x++) begin
            ma[x] = ((x % N) == N - 1) ? -30 * ((x / N) + 1) : 0;
            mb[x] = ((x / N) == N - 1) ? 25 * ((x % N) + 1) : 0;
        end
        load_mats();
        run_mult(1'b0);
        check_c("R2 R5 last-inner-term product");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule